// File: doc/BRIEF.md
# Flash Command Sequencer with Write Protection

This block is the synchronous command front end of a small parallel flash memory. Bus writes, each an address, a data byte and a one-cycle write strobe, are decoded into two-step operations. A sector erase takes a setup byte and then a confirm byte. A byte program takes a setup byte, and the next write supplies the address and data to program. After reset the block is write protected. Erase and program setups are refused until software has written a fixed three-step key of address/data pairs. A write of FFh after either setup cancels the pending operation. It does not turn protection back on.

Each accepted operation runs for a parameter-set number of cycles on an internal down counter. The erase count defaults to about 4 ms at 250 MHz. In the last busy cycle the block pulses a strobe to the memory array. The array sits outside the block: it clears a whole 256-byte sector to FFh on an erase strobe and ANDs the byte into the stored value on a program strobe. While an operation runs, software can poll the block with reads. Bit 7 of the read data is the complement of the byte being written, and bit 6 toggles on every read. Once the operation has finished, reads return array data again.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `mem_prog` and `mem_erase` are 0, `rd_data` is 00h, the block is in read mode, and it is write protected.
- R2: While protected, the setup writes 20h and 10h are ignored, so no later write starts an operation.
- R3: Unprotect needs three consecutive read-mode writes that match (KEY_A0,KEY_D0), (KEY_A1,KEY_D1) and (KEY_A2,KEY_D2). A write that does not match restarts detection. That write counts as the first step if it matches the first pair.
- R4: A write of 20h followed by a write of D0h starts a sector erase. It asserts `mem_erase` for one cycle with `mem_addr` equal to the second write's address with bits 7:0 cleared.
- R5: After a 20h setup, any second write other than D0h starts nothing and returns the block to read mode.
- R6: A write of 10h followed by any write other than FFh starts a byte program. It asserts `mem_prog` for one cycle with that write's address on `mem_addr` and its data on `mem_data`. The array ANDs this data into the stored byte.
- R7: A write of FFh directly after either setup aborts it with no strobe. Protection stays off, so a new setup works without the key.
- R8: Writes that arrive while `busy` is 1 have no effect, and after completion the block is in read mode.
- R9: A read strobe while `busy` is 1 returns, on the next cycle, bit 7 equal to the complement of bit 7 of the byte being written (FFh for erase), with bits 5:0 equal to 0.
- R10: Bit 6 of the busy read data is 0 on the first read of an operation and alternates on each further read.
- R11: A read strobe while not busy returns `arr_rdata` as sampled in the strobe cycle, on `rd_data` in the next cycle.
- R12: `busy` rises in the cycle after the starting write and stays high for exactly ERASE_CYC or PROG_CYC cycles. The strobe falls in the last of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | 8 | Bus write data |
| arr_rdata | input | 8 | Array byte at `bus_addr`, from the memory array |
| rd_data | output | 8 | Read result, valid the cycle after `bus_rd` |
| busy | output | 1 | Operation in progress |
| mem_prog | output | 1 | One-cycle program strobe to the array |
| mem_erase | output | 1 | One-cycle sector erase strobe to the array |
| mem_addr | output | AW | Byte address (program) or sector base (erase) |
| mem_data | output | 8 | Byte to AND into the array on program |

## Verification
A wrong sequencer state has no visible effect until the next write. That write then either starts `busy` a cycle later when it should not, or fails to start it. An operation therefore has to be attempted after each scenario to reveal a stale setup or a stale protection flag. A bad timer count shows up as `busy` falling a cycle early or late, together with a misplaced strobe. A bad toggle or poll state shows up in the first busy read after the strobe.

// File: rtl/fcs_pkg.sv
// Shared types and command codes for the flash command sequencer.
package fcs_pkg;
    // Command byte values decoded on the bus
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h10;
    localparam logic [7:0] CMD_ABORT       = 8'hFF;

    // Command decoder state
    typedef enum logic [1:0] {
        CS_READ      = 2'd0,
        CS_ERASE_SET = 2'd1,
        CS_PROG_SET  = 2'd2
    } cmd_state_t;

    // Kind of running operation
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_t;
endpackage

// File: rtl/fcs_unlock.sv
// Key detector: watches read-mode writes for a fixed three-step
// address/data sequence and pulses unlock on the final matching write.
// Assumes wr_en is already qualified (read mode, not busy).
module fcs_unlock #(
    parameter int AW = 12,
    parameter logic [AW-1:0] KEY_A0 = 'h555,
    parameter logic [7:0]    KEY_D0 = 8'hAA,
    parameter logic [AW-1:0] KEY_A1 = 'h2AA,
    parameter logic [7:0]    KEY_D1 = 8'h55,
    parameter logic [AW-1:0] KEY_A2 = 'h555,
    parameter logic [7:0]    KEY_D2 = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    output logic          unlock
);
    localparam int NSTEP = 3;
    localparam int SW    = $clog2(NSTEP);

    logic [SW-1:0] step_q;
    logic [NSTEP-1:0] hit;

    // Compare the current write against every key step
    always_comb begin
        hit[0] = (addr == KEY_A0) && (data == KEY_D0);
        hit[1] = (addr == KEY_A1) && (data == KEY_D1);
        hit[2] = (addr == KEY_A2) && (data == KEY_D2);
    end

    assign unlock = wr_en && (step_q == SW'(NSTEP-1)) && hit[NSTEP-1];

    // Advance on a match, restart (possibly at step 1) on a mismatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (wr_en) begin
            if (hit[step_q]) begin
                step_q <= (step_q == SW'(NSTEP-1)) ? '0 : step_q + 1'b1;
            end else begin
                step_q <= hit[0] ? SW'(1) : '0;
            end
        end
    end
endmodule

// File: rtl/fcs_cmd_decode.sv
// Command decoder: two-step erase/program setup, abort handling and the
// write-protect flag. Emits a one-cycle start with operation parameters.
// Assumes AW > 8 (256-byte sectors) and that busy comes from the timer.
module fcs_cmd_decode
    import fcs_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          busy,
    input  logic          unlock,
    output logic          key_wr,
    output logic          start,
    output op_kind_t      start_kind,
    output logic [AW-1:0] start_addr,
    output logic [7:0]    start_data
);
    localparam int SECT_BITS = 8;

    cmd_state_t state_q, state_d;
    logic       prot_q;
    logic       wr_ok;

    assign wr_ok  = bus_wr && !busy;
    assign key_wr = wr_ok && (state_q == CS_READ);

    // Next-state and start decode for the two-step sequences
    always_comb begin
        state_d    = state_q;
        start      = 1'b0;
        start_kind = OP_PROG;
        start_addr = bus_addr;
        start_data = bus_wdata;
        if (wr_ok) begin
            unique case (state_q)
                CS_READ: begin
                    if (!prot_q && bus_wdata == CMD_ERASE_SETUP)
                        state_d = CS_ERASE_SET;
                    else if (!prot_q && bus_wdata == CMD_PROG_SETUP)
                        state_d = CS_PROG_SET;
                end
                CS_ERASE_SET: begin
                    state_d = CS_READ;
                    if (bus_wdata == CMD_ERASE_GO) begin
                        start      = 1'b1;
                        start_kind = OP_ERASE;
                        start_addr = {bus_addr[AW-1:SECT_BITS], {SECT_BITS{1'b0}}};
                        start_data = 8'hFF;
                    end
                end
                CS_PROG_SET: begin
                    state_d = CS_READ;
                    if (bus_wdata != CMD_ABORT) begin
                        start      = 1'b1;
                        start_kind = OP_PROG;
                    end
                end
                default: state_d = CS_READ;
            endcase
        end
    end

    // Decoder state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_READ;
        else        state_q <= state_d;
    end

    // Write-protect flag: set by reset, cleared only by the key
    always_ff @(posedge clk) begin
        if (!rst_n)      prot_q <= 1'b1;
        else if (unlock) prot_q <= 1'b0;
    end
endmodule

// File: rtl/fcs_op_timer.sv
// Operation timer: latches the operation, counts its duration down and
// strobes the array in the last busy cycle. Assumes both counts >= 1.
module fcs_op_timer
    import fcs_pkg::*;
#(
    parameter int AW        = 12,
    parameter int ERASE_CYC = 1_000_000,
    parameter int PROG_CYC  = 5_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_kind_t      start_kind,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic          busy,
    output logic          done_prog,
    output logic          done_erase,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    op_kind_t      kind_q;
    logic          last;

    assign busy       = (cnt_q != '0);
    assign last       = (cnt_q == CW'(1));
    assign done_prog  = last && (kind_q == OP_PROG);
    assign done_erase = last && (kind_q == OP_ERASE);

    // Load on start, count down while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (start_kind == OP_ERASE) ? CW'(ERASE_CYC) : CW'(PROG_CYC);
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Hold operation parameters for the strobe and status reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OP_PROG;
            op_addr <= '0;
            op_data <= '0;
        end else if (start) begin
            kind_q  <= start_kind;
            op_addr <= start_addr;
            op_data <= start_data;
        end
    end
endmodule

// File: rtl/fcs_read_port.sv
// Read path: returns array data when idle, poll/toggle status when busy.
// Assumes arr_rdata reflects the array at the bus address in the read cycle.
module fcs_read_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rd,
    input  logic       busy,
    input  logic       start,
    input  logic       poll_bit,
    input  logic [7:0] arr_rdata,
    output logic [7:0] rd_data
);
    logic tog_q;

    // Register read data, flip the toggle bit on each busy read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else begin
            if (start) tog_q <= 1'b0;
            if (bus_rd) begin
                if (busy) begin
                    rd_data <= {~poll_bit, tog_q, 6'b0};
                    tog_q   <= ~tog_q;
                end else begin
                    rd_data <= arr_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer: key detector, command decoder,
// operation timer and read path. The array lives outside the block.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int AW        = 12,
    parameter int ERASE_CYC = 1_000_000,
    parameter int PROG_CYC  = 5_000,
    parameter logic [AW-1:0] KEY_A0 = 'h555,
    parameter logic [7:0]    KEY_D0 = 8'hAA,
    parameter logic [AW-1:0] KEY_A1 = 'h2AA,
    parameter logic [7:0]    KEY_D1 = 8'h55,
    parameter logic [AW-1:0] KEY_A2 = 'h555,
    parameter logic [7:0]    KEY_D2 = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic [7:0]    arr_rdata,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          mem_prog,
    output logic          mem_erase,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data
);
    logic          key_wr, unlock, start;
    op_kind_t      start_kind;
    logic [AW-1:0] start_addr;
    logic [7:0]    start_data;

    fcs_unlock #(
        .AW(AW), .KEY_A0(KEY_A0), .KEY_D0(KEY_D0), .KEY_A1(KEY_A1),
        .KEY_D1(KEY_D1), .KEY_A2(KEY_A2), .KEY_D2(KEY_D2)
    ) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(key_wr),
        .addr(bus_addr), .data(bus_wdata), .unlock(unlock)
    );

    fcs_cmd_decode #(.AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .unlock(unlock), .key_wr(key_wr),
        .start(start), .start_kind(start_kind), .start_addr(start_addr),
        .start_data(start_data)
    );

    fcs_op_timer #(.AW(AW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
        .start_addr(start_addr), .start_data(start_data), .busy(busy),
        .done_prog(mem_prog), .done_erase(mem_erase), .op_addr(mem_addr),
        .op_data(mem_data)
    );

    fcs_read_port u_rd (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .busy(busy), .start(start),
        .poll_bit(mem_data[7]), .arr_rdata(arr_rdata), .rd_data(rd_data)
    );
endmodule

// File: rtl/fcs_chk.sv
// Port-level protocol checks for flash_cmd_seq, attached with bind.
module fcs_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          busy,
    input logic          mem_prog,
    input logic          mem_erase,
    input logic [AW-1:0] mem_addr
);
    // R12
    strobe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog || mem_erase) |-> busy);
    // R12
    strobe_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_prog || mem_erase) |=> !busy);
    // R4
    erase_sector_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase |-> (mem_addr[7:0] == 8'h00));
    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_prog, mem_erase}));
    // R12
    busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_wr) |=> !busy);
    // R8
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_prog && !mem_erase) |=> busy);
endmodule

bind flash_cmd_seq fcs_chk #(.AW(AW)) u_fcs_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .busy(busy),
    .mem_prog(mem_prog), .mem_erase(mem_erase), .mem_addr(mem_addr)
);

// File: tb/tb_flash_cmd_seq.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks on the array contents that the strobes produce.
module tb_flash_cmd_seq;
    localparam int AW = 12;
    localparam int EC = 40;
    localparam int PC = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] arr_rdata, rd_data, mem_data;
    logic busy, mem_prog, mem_erase;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0, cyc = 0, n_prog = 0, n_erase = 0;
    logic [7:0] arr [DEPTH];

    always #2 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .ERASE_CYC(EC), .PROG_CYC(PC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .busy(busy), .mem_prog(mem_prog),
        .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Behavioural array: AND on program, sector fill on erase
    assign arr_rdata = arr[bus_addr];
    initial for (int i = 0; i < DEPTH; i++) arr[i] = 8'(i) ^ 8'h3C;
    always @(posedge clk) begin
        if (rst_n && mem_prog) begin
            arr[mem_addr] <= arr[mem_addr] & mem_data;
            n_prog++;
        end
        if (rst_n && mem_erase) begin
            for (int i = 0; i < 256; i++) arr[{mem_addr[AW-1:8], 8'(i)}] <= 8'hFF;
            n_erase++;
        end
    end

    // Reference model state
    int m_state = 0, m_key = 0, m_cnt = 0;
    bit m_prot = 1, m_busy = 0, m_kind = 0, m_tog = 0, m_ready = 0;
    int m_addr = 0;
    logic [7:0] m_data = 0, m_rd = 0;
    int ka[3] = '{'h555, 'h2AA, 'h555};
    int kd[3] = '{'hAA, 'h55, 'hA5};

    always @(posedge clk) begin
        bit ob;
        if (!rst_n) begin
            m_state = 0; m_key = 0; m_cnt = 0; m_prot = 1; m_busy = 0;
            m_tog = 0; m_rd = 0; m_ready = 1;
        end else begin
            ob = m_busy;
            if (bus_rd) begin
                if (ob) begin m_rd = {~m_data[7], m_tog, 6'b0}; m_tog = ~m_tog; end
                else m_rd = arr[bus_addr];
            end
            if (ob) begin
                if (m_cnt == 1) m_busy = 0;
                m_cnt--;
            end
            if (bus_wr && !ob) begin
                if (m_state == 0) begin
                    if (int'(bus_addr) == ka[m_key] && int'(bus_wdata) == kd[m_key]) begin
                        if (m_key == 2) begin m_prot = 0; m_key = 0; end
                        else m_key++;
                    end else
                        m_key = (int'(bus_addr) == ka[0] && int'(bus_wdata) == kd[0]) ? 1 : 0;
                    if (!m_prot && bus_wdata == 8'h20) m_state = 1;
                    else if (!m_prot && bus_wdata == 8'h10) m_state = 2;
                end else if (m_state == 1) begin
                    m_state = 0;
                    if (bus_wdata == 8'hD0) begin
                        m_busy = 1; m_cnt = EC; m_kind = 1; m_tog = 0;
                        m_addr = int'(bus_addr) & ~255; m_data = 8'hFF;
                    end
                end else begin
                    m_state = 0;
                    if (bus_wdata != 8'hFF) begin
                        m_busy = 1; m_cnt = PC; m_kind = 0; m_tog = 0;
                        m_addr = int'(bus_addr); m_data = bus_wdata;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare DUT against the model away from the clock edge
    always @(negedge clk) begin
        if (rst_n && m_ready) begin
            bit last;
            last = m_busy && m_cnt == 1;
            chk("R12 busy", int'(busy), int'(m_busy));
            chk("R6 mem_prog", int'(mem_prog), int'(last && !m_kind));
            chk("R4 mem_erase", int'(mem_erase), int'(last && m_kind));
            if (last) begin
                chk("R4/R6 mem_addr", int'(mem_addr), m_addr);
                if (!m_kind) chk("R6 mem_data", int'(mem_data), int'(m_data));
            end
            chk("R9/R10/R11 rd_data", int'(rd_data), int'(m_rd));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_wr = 1; bus_addr = AW'(a); bus_wdata = 8'(d);
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd(input int a);
        @(negedge clk); bus_rd = 1; bus_addr = AW'(a);
        @(negedge clk); bus_rd = 0;
    endtask
    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask
    task automatic unkey();
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA5);
    endtask
    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        // R2: protected, setups ignored
        wr('h123, 'h10); wr('h123, 'h00);
        wr('h155, 'h20); wr('h155, 'hD0);
        repeat (3) @(negedge clk);
        chk("R2 no strobe", n_prog + n_erase, 0);
        // R3: broken key, then restart at step 1 via mismatching first pair
        wr('h555, 'hAA); wr('h2AA, 'h54); wr('h555, 'hA5);
        wr('h123, 'h10); wr('h123, 'h00);
        repeat (3) @(negedge clk);
        chk("R3 partial key still protected", n_prog, 0);
        wr('h555, 'hAA); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA5);
        // R6: program with polling reads, R10 toggle
        wr('h0, 'h10); wr('h123, 'h0F);
        for (int i = 0; i < 4; i++) rd('h123);
        wait_idle();
        rd('h123);
        chk("R6/R11 program result", int'(rd_data), 'h0F);
        // R6: ones cannot overwrite zeros
        wr('h0, 'h10); wr('h123, 'hF0);
        rd('h0);
        wait_idle();
        rd('h123);
        chk("R6 AND result", int'(rd_data), 'h00);
        // R4: sector erase with polling, R8 writes during busy
        wr('h0, 'h20); wr('h155, 'hD0);
        rd('h155); rd('h155);
        wr('h0, 'h10); wr('h0, 'h20); wr('h2AA, 'hD0);
        rd('h155);
        wait_idle();
        wr('h300, 'h00);
        repeat (2) @(negedge clk);
        chk("R8 no leftover setup", n_prog, 2);
        rd('h155); chk("R4 erased", int'(rd_data), 'hFF);
        rd('h123); chk("R4 erased", int'(rd_data), 'hFF);
        rd('h200); chk("R4 next sector kept", int'(rd_data), 'h3C);
        rd('h0FF); chk("R4 prev sector kept", int'(rd_data), 'hC3);
        // R4: erase again harmlessly
        wr('h0, 'h20); wr('h1FF, 'hD0); wait_idle();
        rd('h1FF); chk("R4 re-erase", int'(rd_data), 'hFF);
        // R5: wrong confirm byte
        wr('h0, 'h20); wr('h200, 'h55);
        wr('h200, 'hD0);
        repeat (3) @(negedge clk);
        chk("R5 no erase", n_erase, 2);
        // R7: abort after both setups, protection stays off
        wr('h0, 'h10); wr('h201, 'hFF);
        wr('h0, 'h20); wr('h201, 'hFF);
        repeat (2) @(negedge clk);
        chk("R7 abort no strobe", n_prog + n_erase, 4);
        rd('h201); chk("R7 data kept", int'(rd_data), 'h3D);
        wr('h0, 'h10); wr('h201, 'h01); wait_idle();
        rd('h201); chk("R7 program after abort", int'(rd_data), 'h01);
        // R1: reset re-protects
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        wr('h0, 'h10); wr('h202, 'h00);
        repeat (3) @(negedge clk);
        chk("R1 protected after reset", n_prog, 3);
        summary();
    end
endmodule